// File: doc/BRIEF.md
# Next-PC and Control-Transfer Unit

This block decides where a 32-bit, word-aligned core fetches next. Once per clock it takes the current program counter, a transfer class and the operands of the instruction being retired. It then registers the next PC. The transfer can be one of these:

- sequential flow;
- a PC-relative branch, either unconditional or conditional on a comparison of two register operands;
- an absolute jump that stays inside the current 256 MB region;
- a jump or call through a register;
- a return from an exception or from a break.

Calls drive the return-address write (destination register 31) with the address of the following instruction. Return forms ask for the matching saved status word to be restored.

A register-indirect transfer whose target is not word aligned is refused. The unit redirects to a fixed exception vector and raises a one-cycle fault request. It records the faulting target and the address of the instruction after the faulting one. Instruction fetch and the register file sit outside the block. The surrounding pipeline feeds the unit one retired instruction per cycle.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pc_q` loads `RESET_VEC` (default 0x00000000), and `fault_req`, `fault_addr` and `fault_epc` clear to zero.
- R2: Class 0 (sequential) makes the next `pc_q` equal to `pc_q + 4`.
- R3: For class 2 (always branch), and for class 1 when its condition holds, the next PC is `pc_q + 4 + (sign-extended br_imm with bits 1:0 cleared)`. For class 1 when its condition fails, the next PC is `pc_q + 4`.
- R4: `cmp_sel` selects how class 1 compares `opa` with `opb`: 0 equal, 1 not equal, 2 signed greater-or-equal, 3 signed less-than, 4 unsigned greater-or-equal, 5 unsigned less-than. Codes 6 and 7 never take the branch.
- R5: Classes 3 (jump) and 4 (call) load `{pc_q[31:28], jmp_imm, 2'b00}`, so the top four PC bits are kept.
- R6: `link_we` is 1 only for class 4, and for class 6 with an aligned target. Whenever it is 1, `link_data` equals `pc_q + 4`.
- R7: Classes 5 (jump through register) and 6 (call through register) with `opa[1:0] == 0` load `opa` into the PC.
- R8: Classes 5 and 6 with `opa[1:0] != 0` load `EXC_VEC` (default 0x00000020) into the PC and set `fault_req` for the following cycle. They also capture `opa` in `fault_addr` and `pc_q + 4` in `fault_epc`. No link write happens.
- R9: Class 7 loads `exc_ret_addr` and class 8 loads `brk_ret_addr`. During that cycle, `status_restore` is 1 and `status_value` carries `exc_saved_status` or `brk_saved_status` respectively. In every other class `status_restore` is 0.
- R10: `fault_req` is 0 after any non-faulting transfer. `fault_addr` and `fault_epc` keep their values until the next fault.
- R11: Class codes 9 to 15 behave as sequential, with no link write and no status restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_cls | input | 4 | Transfer class of the retiring instruction |
| cmp_sel | input | 3 | Comparison selector for conditional branches |
| br_imm | input | 16 | Branch displacement in bytes |
| jmp_imm | input | 26 | Absolute jump word index |
| opa | input | 32 | First register operand, also the indirect target |
| opb | input | 32 | Second register operand |
| exc_ret_addr | input | 32 | Saved exception return address |
| brk_ret_addr | input | 32 | Saved break return address |
| exc_saved_status | input | 32 | Status saved on exception entry |
| brk_saved_status | input | 32 | Status saved on break entry |
| pc_q | output | 32 | Registered program counter |
| link_we | output | 1 | Return-address register write enable |
| link_data | output | 32 | Return-address value |
| status_restore | output | 1 | Restore status this cycle |
| status_value | output | 32 | Status word to restore |
| fault_req | output | 1 | Misaligned-target exception request |
| fault_addr | output | 32 | Captured misaligned target |
| fault_epc | output | 32 | Address after the faulting instruction |

## Verification
The bench sweeps every comparison code over operand pairs straddling the sign boundary, such as 0x7FFFFFFF against 0x80000000. A unit that mixes up signed and unsigned compares, or swaps the operands, takes the wrong branches there. Branch displacements include odd and negative values, so a unit that forgets to clear the two low bits produces a misaligned PC, and one that forgets sign extension jumps forward instead of back. Absolute jumps are issued from all sixteen regions, which exposes any design that drops or zeroes the top PC bits. Every low-bit pattern is tried on both register-indirect classes, which catches a design that jumps anyway, writes the link on a refused call, captures the PC instead of the target, or leaves the fault request high after the next instruction.

// File: rtl/npc_pkg.sv
// Package npc_pkg
// Shared encodings for the next-PC unit: transfer classes and branch
// comparison selectors. Assumes a 32-bit word-aligned instruction stream.
package npc_pkg;

    typedef enum logic [3:0] {
        XFER_SEQ  = 4'd0,
        XFER_BCND = 4'd1,
        XFER_BRA  = 4'd2,
        XFER_JABS = 4'd3,
        XFER_CABS = 4'd4,
        XFER_JREG = 4'd5,
        XFER_CREG = 4'd6,
        XFER_RETX = 4'd7,
        XFER_RETB = 4'd8
    } xfer_e;

    typedef enum logic [2:0] {
        CMP_EQ  = 3'd0,
        CMP_NE  = 3'd1,
        CMP_GE  = 3'd2,
        CMP_LT  = 3'd3,
        CMP_GEU = 3'd4,
        CMP_LTU = 3'd5
    } cmp_e;

    localparam int INSN_BYTES = 4;
    localparam int ALIGN_W    = 2;

endpackage

// File: rtl/npc_branch_cmp.sv
// Module npc_branch_cmp
// Evaluates a conditional-branch comparison between two register operands.
// Assumes selector codes from npc_pkg; unknown codes never take the branch.
module npc_branch_cmp #(
    parameter int XLEN = 32
) (
    input  logic [2:0]      cmp_sel,
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    output logic            taken
);
    import npc_pkg::*;

    // Select the comparison named by cmp_sel.
    always_comb begin
        case (cmp_sel)
            CMP_EQ:  taken = (lhs == rhs);
            CMP_NE:  taken = (lhs != rhs);
            CMP_GE:  taken = ($signed(lhs) >= $signed(rhs));
            CMP_LT:  taken = ($signed(lhs) <  $signed(rhs));
            CMP_GEU: taken = (lhs >= rhs);
            CMP_LTU: taken = (lhs <  rhs);
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target_gen.sv
// Module npc_target_gen
// Forms the candidate targets of every transfer class from the current PC:
// sequential, PC-relative branch, region-preserving absolute jump, and the
// alignment status of a register target. Purely combinational.
module npc_target_gen #(
    parameter int XLEN     = 32,
    parameter int BIMM_W   = 16,
    parameter int REGION_W = 4,
    localparam int ALIGN_W = npc_pkg::ALIGN_W,
    localparam int JIMM_W  = XLEN - REGION_W - ALIGN_W
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [BIMM_W-1:0] br_imm,
    input  logic [JIMM_W-1:0] jmp_imm,
    input  logic [XLEN-1:0]   reg_tgt,
    output logic [XLEN-1:0]   seq_pc,
    output logic [XLEN-1:0]   br_pc,
    output logic [XLEN-1:0]   abs_pc,
    output logic              reg_misaligned
);
    logic [XLEN-1:0] br_off;

    // Sign-extend the displacement and force word alignment.
    always_comb begin
        br_off = {{(XLEN-BIMM_W){br_imm[BIMM_W-1]}}, br_imm[BIMM_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
        seq_pc = pc + XLEN'(npc_pkg::INSN_BYTES);
        br_pc  = seq_pc + br_off;
        reg_misaligned = |reg_tgt[ALIGN_W-1:0];
    end

    // Absolute target keeps the region bits of the current PC when present.
    generate
        if (REGION_W > 0) begin : g_region
            assign abs_pc = {pc[XLEN-1 -: REGION_W], jmp_imm, {ALIGN_W{1'b0}}};
        end else begin : g_flat
            assign abs_pc = {jmp_imm, {ALIGN_W{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/npc_unit.sv
// Module npc_unit
// Next-PC and control-transfer unit. Registers the next program counter,
// drives the return-address write for calls, requests status restore for
// return forms, and raises a one-cycle fault for misaligned register targets.
// Assumes one retired instruction per cycle presented on the inputs.
module npc_unit #(
    parameter int XLEN     = 32,
    parameter int BIMM_W   = 16,
    parameter int REGION_W = 4,
    parameter int STATUS_W = 32,
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_0000,
    parameter logic [XLEN-1:0] EXC_VEC   = 32'h0000_0020,
    localparam int JIMM_W = XLEN - REGION_W - npc_pkg::ALIGN_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          xfer_cls,
    input  logic [2:0]          cmp_sel,
    input  logic [BIMM_W-1:0]   br_imm,
    input  logic [JIMM_W-1:0]   jmp_imm,
    input  logic [XLEN-1:0]     opa,
    input  logic [XLEN-1:0]     opb,
    input  logic [XLEN-1:0]     exc_ret_addr,
    input  logic [XLEN-1:0]     brk_ret_addr,
    input  logic [STATUS_W-1:0] exc_saved_status,
    input  logic [STATUS_W-1:0] brk_saved_status,
    output logic [XLEN-1:0]     pc_q,
    output logic                link_we,
    output logic [XLEN-1:0]     link_data,
    output logic                status_restore,
    output logic [STATUS_W-1:0] status_value,
    output logic                fault_req,
    output logic [XLEN-1:0]     fault_addr,
    output logic [XLEN-1:0]     fault_epc
);
    import npc_pkg::*;

    logic            cond_taken;
    logic [XLEN-1:0] seq_pc, br_pc, abs_pc, next_pc;
    logic            reg_misaligned, fault_now;

    npc_branch_cmp #(.XLEN(XLEN)) u_cmp (
        .cmp_sel (cmp_sel),
        .lhs     (opa),
        .rhs     (opb),
        .taken   (cond_taken)
    );

    npc_target_gen #(.XLEN(XLEN), .BIMM_W(BIMM_W), .REGION_W(REGION_W)) u_tgt (
        .pc             (pc_q),
        .br_imm         (br_imm),
        .jmp_imm        (jmp_imm),
        .reg_tgt        (opa),
        .seq_pc         (seq_pc),
        .br_pc          (br_pc),
        .abs_pc         (abs_pc),
        .reg_misaligned (reg_misaligned)
    );

    assign link_data = seq_pc;

    // Choose the next PC and the side effects of the current transfer class.
    always_comb begin
        next_pc        = seq_pc;
        fault_now      = 1'b0;
        link_we        = 1'b0;
        status_restore = 1'b0;
        status_value   = '0;
        case (xfer_cls)
            XFER_BCND: if (cond_taken) next_pc = br_pc;
            XFER_BRA:  next_pc = br_pc;
            XFER_JABS: next_pc = abs_pc;
            XFER_CABS: begin
                next_pc = abs_pc;
                link_we = 1'b1;
            end
            XFER_JREG, XFER_CREG: begin
                if (reg_misaligned) begin
                    fault_now = 1'b1;
                    next_pc   = EXC_VEC;
                end else begin
                    next_pc = opa;
                    link_we = (xfer_cls == XFER_CREG);
                end
            end
            XFER_RETX: begin
                next_pc        = exc_ret_addr;
                status_restore = 1'b1;
                status_value   = exc_saved_status;
            end
            XFER_RETB: begin
                next_pc        = brk_ret_addr;
                status_restore = 1'b1;
                status_value   = brk_saved_status;
            end
            default: next_pc = seq_pc;
        endcase
    end

    // Register the PC and the fault record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q       <= RESET_VEC;
            fault_req  <= 1'b0;
            fault_addr <= '0;
            fault_epc  <= '0;
        end else begin
            pc_q      <= next_pc;
            fault_req <= fault_now;
            if (fault_now) begin
                fault_addr <= opa;
                fault_epc  <= seq_pc;
            end
        end
    end
endmodule

// File: rtl/npc_unit_chk.sv
// Module npc_unit_chk
// Property checker for npc_unit, attached by bind. Observes ports only.
module npc_unit_chk #(
    parameter int XLEN     = 32,
    parameter int STATUS_W = 32,
    parameter logic [XLEN-1:0] EXC_VEC = 32'h0000_0020
) (
    input logic                clk,
    input logic                rst_n,
    input logic [3:0]          xfer_cls,
    input logic [XLEN-1:0]     opa,
    input logic [XLEN-1:0]     exc_ret_addr,
    input logic [XLEN-1:0]     pc_q,
    input logic                link_we,
    input logic                status_restore,
    input logic                fault_req,
    input logic [XLEN-1:0]     fault_addr
);
    import npc_pkg::*;

    logic bad_reg;
    assign bad_reg = (xfer_cls == XFER_JREG || xfer_cls == XFER_CREG) && (opa[1:0] != 2'b00);

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_cls == XFER_SEQ) |=> (pc_q == $past(pc_q) + 32'd4)); // R2

    AST_REGION_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_cls == XFER_JABS) |=> (pc_q[XLEN-1 -: 4] == $past(pc_q[XLEN-1 -: 4]))); // R5

    AST_NO_LINK_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        bad_reg |-> !link_we); // R6

    AST_FAULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_reg |=> (fault_req && pc_q == EXC_VEC && fault_addr == $past(opa))); // R8

    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_reg |=> !fault_req); // R10

    AST_ERET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_cls == XFER_RETX) |=> (pc_q == $past(exc_ret_addr))); // R9

    AST_RESTORE_ONLY_RET: assert property (@(posedge clk) disable iff (!rst_n)
        status_restore |-> (xfer_cls == XFER_RETX || xfer_cls == XFER_RETB)); // R9
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .STATUS_W(STATUS_W), .EXC_VEC(EXC_VEC)) u_npc_unit_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .xfer_cls       (xfer_cls),
    .opa            (opa),
    .exc_ret_addr   (exc_ret_addr),
    .pc_q           (pc_q),
    .link_we        (link_we),
    .status_restore (status_restore),
    .fault_req      (fault_req),
    .fault_addr     (fault_addr)
);

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
// Bench for npc_unit: sweeps comparison codes, displacements, regions,
// alignment patterns and class codes against an arithmetic model.
module npc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  xfer_cls;
    logic [2:0]  cmp_sel;
    logic [15:0] br_imm;
    logic [25:0] jmp_imm;
    logic [31:0] opa, opb, exc_ret_addr, brk_ret_addr, exc_saved_status, brk_saved_status;
    logic [31:0] pc_q, link_data, status_value, fault_addr, fault_epc;
    logic        link_we, status_restore, fault_req;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_pc, m_faddr, m_fepc;
    logic        m_freq;

    always #2.5 clk = ~clk;

    npc_unit u_npc_unit (
        .clk(clk), .rst_n(rst_n), .xfer_cls(xfer_cls), .cmp_sel(cmp_sel),
        .br_imm(br_imm), .jmp_imm(jmp_imm), .opa(opa), .opb(opb),
        .exc_ret_addr(exc_ret_addr), .brk_ret_addr(brk_ret_addr),
        .exc_saved_status(exc_saved_status), .brk_saved_status(brk_saved_status),
        .pc_q(pc_q), .link_we(link_we), .link_data(link_data),
        .status_restore(status_restore), .status_value(status_value),
        .fault_req(fault_req), .fault_addr(fault_addr), .fault_epc(fault_epc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic cmp_model(input logic [2:0] s, input logic [31:0] a, input logic [31:0] b);
        case (s)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd2: return $signed(a) >= $signed(b);
            3'd3: return $signed(a) < $signed(b);
            3'd4: return a >= b;
            3'd5: return a < b;
            default: return 1'b0;
        endcase
    endfunction

    // Drive one instruction at a falling edge, check combinational outputs,
    // then check registered outputs at the next falling edge.
    task automatic step(input logic [3:0] c, input logic [2:0] s, input logic [15:0] bi,
                        input logic [25:0] ji, input logic [31:0] a, input logic [31:0] b,
                        input string req);
        logic [31:0] seq, nxt, off, st_v;
        logic        lwe, st_r, flt;
        xfer_cls = c; cmp_sel = s; br_imm = bi; jmp_imm = ji; opa = a; opb = b;
        seq = m_pc + 32'd4;
        off = {{16{bi[15]}}, bi} & 32'hFFFF_FFFC;
        nxt = seq; lwe = 1'b0; st_r = 1'b0; st_v = 32'd0; flt = 1'b0;
        case (c)
            4'd1: if (cmp_model(s, a, b)) nxt = seq + off;
            4'd2: nxt = seq + off;
            4'd3: nxt = {m_pc[31:28], ji, 2'b00};
            4'd4: begin nxt = {m_pc[31:28], ji, 2'b00}; lwe = 1'b1; end
            4'd5, 4'd6: begin
                if (a[1:0] != 2'b00) begin flt = 1'b1; nxt = 32'h0000_0020; end
                else begin nxt = a; lwe = (c == 4'd6); end
            end
            4'd7: begin nxt = exc_ret_addr; st_r = 1'b1; st_v = exc_saved_status; end
            4'd8: begin nxt = brk_ret_addr; st_r = 1'b1; st_v = brk_saved_status; end
            default: ;
        endcase
        #1;
        chk({req, " link_we"}, {31'd0, link_we}, {31'd0, lwe});
        if (lwe) chk({req, " link_data"}, link_data, seq);
        chk({req, " status_restore"}, {31'd0, status_restore}, {31'd0, st_r});
        if (st_r) chk({req, " status_value"}, status_value, st_v);
        if (flt) begin m_faddr = a; m_fepc = seq; end
        m_freq = flt;
        m_pc = nxt;
        @(negedge clk);
        chk({req, " pc"}, pc_q, m_pc);
        chk({req, " fault_req"}, {31'd0, fault_req}, {31'd0, m_freq});
        chk({req, " fault_addr"}, fault_addr, m_faddr);
        chk({req, " fault_epc"}, fault_epc, m_fepc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] vals [6];
        logic [15:0] imms [5];
        int k;
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
        vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h0000_0005;
        imms[0] = 16'h0010; imms[1] = 16'h0007; imms[2] = 16'hFFF4;
        imms[3] = 16'h8003; imms[4] = 16'h7FFF;
        exc_ret_addr = 32'h0000_4440; brk_ret_addr = 32'h0000_8880;
        exc_saved_status = 32'h0000_0005; brk_saved_status = 32'h0000_000A;
        xfer_cls = 4'd0; cmp_sel = 3'd0; br_imm = '0; jmp_imm = '0; opa = '0; opb = '0;
        rst_n = 1'b0;
        m_pc = 32'd0; m_faddr = 32'd0; m_fepc = 32'd0; m_freq = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pc", pc_q, 32'h0000_0000);
        chk("R1 fault_req", {31'd0, fault_req}, 32'd0);
        chk("R1 fault_addr", fault_addr, 32'd0);
        rst_n = 1'b1;

        // R2: sequential flow
        for (int i = 0; i < 4; i++) step(4'd0, 3'd0, 16'h0, 26'h0, 32'h0, 32'h0, "R2 seq");

        // R3 R4: every comparison code against boundary operand pairs
        k = 0;
        for (int s = 0; s < 8; s++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++) begin
                    step(4'd5, 3'd0, 16'h0, 26'h0, 32'h1000_0100, 32'h0, "R7 set pc");
                    step(4'd1, 3'(s), imms[k % 5], 26'h0, vals[i], vals[j], "R4 cond branch");
                    k++;
                end

        // R3: unconditional branch, odd and negative displacements
        for (int i = 0; i < 5; i++) begin
            step(4'd5, 3'd0, 16'h0, 26'h0, 32'h2000_0200, 32'h0, "R7 set pc");
            step(4'd2, 3'd0, imms[i], 26'h0, 32'h0, 32'h0, "R3 branch");
        end

        // R5 R6: absolute jumps and calls from every region
        for (int r = 0; r < 16; r++) begin
            step(4'd5, 3'd0, 16'h0, 26'h0, {4'(r), 28'h000_0100}, 32'h0, "R7 set pc");
            step(4'd3, 3'd0, 16'h0, 26'h3FF_FFFF - 26'(r), 32'h0, 32'h0, "R5 jump abs");
            step(4'd4, 3'd0, 16'h0, 26'h000_1234 + 26'(r), 32'h0, 32'h0, "R6 call abs");
        end

        // R7 R8 R10: every low-bit pattern through both register forms
        for (int c = 5; c <= 6; c++)
            for (int lo = 0; lo < 4; lo++) begin
                step(4'(c), 3'd0, 16'h0, 26'h0, 32'h0003_1000 | 32'(lo), 32'h0, "R8 reg target");
                step(4'd0, 3'd0, 16'h0, 26'h0, 32'h0, 32'h0, "R10 after reg");
            end
        // back-to-back faults, then recovery
        step(4'd6, 3'd0, 16'h0, 26'h0, 32'h0000_0043, 32'h0, "R8 fault one");
        step(4'd5, 3'd0, 16'h0, 26'h0, 32'h0000_0082, 32'h0, "R8 fault two");
        step(4'd2, 3'd0, 16'h0008, 26'h0, 32'h0, 32'h0, "R10 recover");

        // R9: returns from exception and break
        step(4'd7, 3'd0, 16'h0, 26'h0, 32'h0, 32'h0, "R9 eret");
        step(4'd8, 3'd0, 16'h0, 26'h0, 32'h0, 32'h0, "R9 bret");

        // R11: unused class codes behave as sequential
        for (int c = 9; c < 16; c++) step(4'(c), 3'd0, 16'h0100, 26'h0, 32'h0000_0001, 32'h0, "R11 unused class");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule